// File: doc/BRIEF.md
# Bridge Diagnostic Fault Register

This block keeps the diagnostic status byte of a motor H-bridge driver. Protection logic hands it single-cycle fault pulses: current limiting, temperature-driven current reduction, over-temperature, short to ground or to supply per output, a short across the load, and a digital open-load flag. The block latches each fault. It folds the per-output faults into a two-bit code per output, using a fixed priority. It presents the result as one active-low byte for a serial read-out path. The byte is all ones when nothing is wrong.

Live inputs also shape the byte. The enable pair sets the top bit directly, with nothing latched. Supply under-voltage blanks the per-output fields while it lasts and leaves the stored faults untouched, so they come back once the supply recovers. The stored faults are wiped by four events:
- a clear request from a valid diagnostic read,
- entry into serial mode,
- a rising enable while disable is low,
- a falling disable while enable is high.

A summary output reports whether any latched fault is held, for use as a status flag.

Top module: `diag_fault_reg`

## Requirements
- R1: While reset is asserted, `diag_byte` is 8'hFF and `fault_stored` is 0.
- R2: Bit 7 of `diag_byte` is 1 exactly when `en_in` was 1 and `dis_in` was 0 at the previous clock edge. The bit is not latched. Every output reflects the inputs sampled at the previous edge.
- R3: A pulse on `ev_cur_lim`, `ev_cur_red` or `ev_over_temp` drives bit 4, bit 5 or bit 6 (in that order) to 0. The bit stays 0 until a clear.
- R4: Bits 1:0 form the output-1 field and bits 3:2 form the output-2 field. Each field reads 11 for no fault, 01 for a stored short to ground, and 10 for a stored short to supply. A stored open-load flag sets both fields to 00.
- R5: A stored load short shows as 01 in the output-1 field and 10 in the output-2 field, overriding every other short and open load.
- R6: On one output, a short to ground outranks a short to supply. Any short outranks open load in that field.
- R7: While `uv_in` is 1, bits 3:0 read 0000. When it returns to 0, the fields show the stored faults again.
- R8: Stored faults clear on `clr_req`, on `mode_enter`, on a rise of `en_in` while `dis_in` is 0, and on a fall of `dis_in` while `en_in` is 1. A rise of `en_in` while `dis_in` is 1 does not clear.
- R9: A fault pulse in the same cycle as a clear stays stored.
- R10: `fault_stored` is 1 exactly when at least one latched fault is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_in | input | 1 | Bridge enable level |
| dis_in | input | 1 | Bridge disable level |
| uv_in | input | 1 | Supply under-voltage, live |
| mode_enter | input | 1 | Pulse on entry into serial mode |
| clr_req | input | 1 | Clear pulse after a valid diagnostic read |
| ev_cur_lim | input | 1 | Current-limit event pulse |
| ev_cur_red | input | 1 | Temperature current-reduction event pulse |
| ev_over_temp | input | 1 | Over-temperature event pulse |
| ev_short_gnd | input | N_OUT | Per-output short-to-ground event pulses |
| ev_short_sup | input | N_OUT | Per-output short-to-supply event pulses |
| ev_load_short | input | 1 | Short-across-load event pulse |
| ev_open_load | input | 1 | Open-load flag pulse |
| diag_byte | output | 4+2*N_OUT | Active-low encoded status |
| fault_stored | output | 1 | Any latched fault held |

## Verification
The bench builds the block with the default N_OUT = 2. This gives exactly the 8-bit layout. Both per-output fields can be reached, and so can the alternating 01/10 load-short code on the two fields. A bench-side model tracks the stored faults and the enable history. Runs of stimulus then stack faults of different rank on the same output and on both outputs. Along the way they cover masking and restoring under under-voltage, each clear source including the non-clearing enable rise, and a fault pulse that coincides with a clear.

// File: rtl/diag_pkg.sv
package diag_pkg;

  localparam logic [1:0] FLD_CLEAN = 2'b11;
  localparam logic [1:0] FLD_GND   = 2'b01;
  localparam logic [1:0] FLD_SUP   = 2'b10;
  localparam logic [1:0] FLD_OPEN  = 2'b00;
  localparam logic [1:0] FLD_BLANK = 2'b00;

  localparam int CTRL_BITS = 4;
  localparam int SHARED_FLAGS = 5;

  localparam int IDX_LIM    = 0;
  localparam int IDX_RED    = 1;
  localparam int IDX_OT     = 2;
  localparam int IDX_LSHORT = 3;
  localparam int IDX_OPEN   = 4;

  function automatic logic [1:0] load_short_code(input int idx);
    return (idx % 2 == 0) ? FLD_GND : FLD_SUP;
  endfunction

endpackage

// File: rtl/diag_rst_sync.sv
module diag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/diag_clr_gen.sv
module diag_clr_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  input  logic dis_in,
  input  logic clr_req,
  input  logic mode_enter,
  output logic clr
);

  logic en_q;
  logic dis_q;
  logic en_rise;
  logic dis_fall;

  always_comb begin
    en_rise  = en_in & ~en_q;
    dis_fall = ~dis_in & dis_q;
    clr      = clr_req | mode_enter | (en_rise & ~dis_in) | (dis_fall & en_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      dis_q <= 1'b1;
    end else begin
      en_q  <= en_in;
      dis_q <= dis_in;
    end
  end

  // R8: an enable rise with disable low must raise the clear
  p_en_rise_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en_in) && !dis_in) |-> clr);

  // R8: a disable fall with enable high must raise the clear
  p_dis_fall_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dis_in) && en_in) |-> clr);

endmodule

// File: rtl/diag_flag_store.sv
module diag_flag_store
  import diag_pkg::*;
#(
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev_lim,
  input  logic             ev_red,
  input  logic             ev_ot,
  input  logic             ev_lshort,
  input  logic             ev_open,
  input  logic [N_OUT-1:0] ev_gnd,
  input  logic [N_OUT-1:0] ev_sup,
  output logic             lim_q,
  output logic             red_q,
  output logic             ot_q,
  output logic             lshort_q,
  output logic             open_q,
  output logic [N_OUT-1:0] gnd_q,
  output logic [N_OUT-1:0] sup_q,
  output logic             any_q
);

  localparam int SW = SHARED_FLAGS + 2 * N_OUT;

  logic [SW-1:0] ev_vec;
  logic [SW-1:0] st_q;
  logic [SW-1:0] st_d;
  logic          st_en;

  always_comb begin
    ev_vec             = '0;
    ev_vec[IDX_LIM]    = ev_lim;
    ev_vec[IDX_RED]    = ev_red;
    ev_vec[IDX_OT]     = ev_ot;
    ev_vec[IDX_LSHORT] = ev_lshort;
    ev_vec[IDX_OPEN]   = ev_open;
    ev_vec[SHARED_FLAGS +: N_OUT]         = ev_gnd;
    ev_vec[SHARED_FLAGS + N_OUT +: N_OUT] = ev_sup;
  end

  // a clear drops old content, but events of the same cycle survive
  always_comb begin
    st_en = clr | (|ev_vec);
    if (clr) begin
      st_d = ev_vec;
    end else begin
      st_d = st_q | ev_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign lim_q    = st_q[IDX_LIM];
  assign red_q    = st_q[IDX_RED];
  assign ot_q     = st_q[IDX_OT];
  assign lshort_q = st_q[IDX_LSHORT];
  assign open_q   = st_q[IDX_OPEN];
  assign gnd_q    = st_q[SHARED_FLAGS +: N_OUT];
  assign sup_q    = st_q[SHARED_FLAGS + N_OUT +: N_OUT];
  assign any_q    = |st_q;

  // R3: a latched over-temperature stays until a clear
  p_ot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_q && !clr) |=> ot_q);

  // R8: a clear with no concurrent event empties the store
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (ev_vec == '0)) |=> (any_q == 1'b0));

  // R9: an event in a clear cycle is still held afterwards
  p_event_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev_lim) |=> lim_q);

endmodule

// File: rtl/diag_field_enc.sv
module diag_field_enc
  import diag_pkg::*;
#(
  parameter int N_OUT = 2
) (
  input  logic               uv,
  input  logic               lshort,
  input  logic               open,
  input  logic [N_OUT-1:0]   gnd,
  input  logic [N_OUT-1:0]   sup,
  output logic [2*N_OUT-1:0] fields
);

  for (genvar g = 0; g < N_OUT; g++) begin : g_fld
    logic [1:0] code;
    always_comb begin
      if (uv) begin
        code = FLD_BLANK;
      end else if (lshort) begin
        code = load_short_code(g);
      end else if (gnd[g]) begin
        code = FLD_GND;
      end else if (sup[g]) begin
        code = FLD_SUP;
      end else if (open) begin
        code = FLD_OPEN;
      end else begin
        code = FLD_CLEAN;
      end
    end
    assign fields[2*g +: 2] = code;
  end

endmodule

// File: rtl/diag_fault_reg.sv
module diag_fault_reg
  import diag_pkg::*;
#(
  parameter int N_OUT = 2,
  localparam int FW = 2 * N_OUT,
  localparam int DW = CTRL_BITS + FW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_in,
  input  logic             dis_in,
  input  logic             uv_in,
  input  logic             mode_enter,
  input  logic             clr_req,
  input  logic             ev_cur_lim,
  input  logic             ev_cur_red,
  input  logic             ev_over_temp,
  input  logic [N_OUT-1:0] ev_short_gnd,
  input  logic [N_OUT-1:0] ev_short_sup,
  input  logic             ev_load_short,
  input  logic             ev_open_load,
  output logic [DW-1:0]    diag_byte,
  output logic             fault_stored
);

  logic             rst_int_n;
  logic             clr;
  logic             lim_q;
  logic             red_q;
  logic             ot_q;
  logic             lshort_q;
  logic             open_q;
  logic [N_OUT-1:0] gnd_q;
  logic [N_OUT-1:0] sup_q;
  logic             any_q;
  logic             bridge_on_q;
  logic             bridge_on_d;
  logic             uv_q;
  logic [FW-1:0]    fields;

  diag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  diag_clr_gen u_clr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en_in      (en_in),
    .dis_in     (dis_in),
    .clr_req    (clr_req),
    .mode_enter (mode_enter),
    .clr        (clr)
  );

  diag_flag_store #(.N_OUT(N_OUT)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (clr),
    .ev_lim    (ev_cur_lim),
    .ev_red    (ev_cur_red),
    .ev_ot     (ev_over_temp),
    .ev_lshort (ev_load_short),
    .ev_open   (ev_open_load),
    .ev_gnd    (ev_short_gnd),
    .ev_sup    (ev_short_sup),
    .lim_q     (lim_q),
    .red_q     (red_q),
    .ot_q      (ot_q),
    .lshort_q  (lshort_q),
    .open_q    (open_q),
    .gnd_q     (gnd_q),
    .sup_q     (sup_q),
    .any_q     (any_q)
  );

  diag_field_enc #(.N_OUT(N_OUT)) u_enc (
    .uv     (uv_q),
    .lshort (lshort_q),
    .open   (open_q),
    .gnd    (gnd_q),
    .sup    (sup_q),
    .fields (fields)
  );

  // live inputs are sampled once so every output bit shares one latency
  always_comb begin
    bridge_on_d = en_in & ~dis_in;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bridge_on_q <= 1'b1;
      uv_q        <= 1'b0;
    end else begin
      bridge_on_q <= bridge_on_d;
      uv_q        <= uv_in;
    end
  end

  always_comb begin
    diag_byte = {bridge_on_q, ~ot_q, ~red_q, ~lim_q, fields};
  end

  assign fault_stored = any_q;

  // R2: top bit follows the enable pair one edge later
  p_bridge_bit_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en_in && !dis_in) |=> diag_byte[DW-1]);

  p_bridge_off_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(en_in && !dis_in) |=> !diag_byte[DW-1]);

  // R7: fields blanked during under-voltage
  p_uv_blank_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    uv_in |=> (diag_byte[FW-1:0] == '0));

  // R5: a load short outside under-voltage shows the ground code on field 0
  p_load_short_code_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ev_load_short && !uv_in) |=> (diag_byte[1:0] == FLD_GND));

  // R10: a low over-temperature bit implies the summary is set
  p_summary_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !diag_byte[FW+2] |-> fault_stored);

endmodule

// File: tb/sim_diag_fault_reg.sv
`timescale 1ns/1ps
module sim_diag_fault_reg;

  localparam int N_OUT = 2;

  // stimulus mask bits
  localparam int B_LIM = 0, B_RED = 1, B_OT = 2, B_G0 = 3, B_G1 = 4,
                 B_S0 = 5, B_S1 = 6, B_LS = 7, B_OL = 8, B_CLR = 9, B_MODE = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic en_in, dis_in, uv_in, mode_enter, clr_req;
  logic ev_cur_lim, ev_cur_red, ev_over_temp, ev_load_short, ev_open_load;
  logic [N_OUT-1:0] ev_short_gnd, ev_short_sup;
  logic [7:0] diag_byte;
  logic fault_stored;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] b;
    logic       sf;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t mon_it;

  // bench model state
  logic m_lim, m_red, m_ot, m_ls, m_ol;
  logic [1:0] m_gnd, m_sup;
  logic m_en_p, m_dis_p;

  always #4 clk = ~clk;

  diag_fault_reg #(.N_OUT(N_OUT)) u0 (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .dis_in(dis_in), .uv_in(uv_in),
    .mode_enter(mode_enter), .clr_req(clr_req), .ev_cur_lim(ev_cur_lim),
    .ev_cur_red(ev_cur_red), .ev_over_temp(ev_over_temp),
    .ev_short_gnd(ev_short_gnd), .ev_short_sup(ev_short_sup),
    .ev_load_short(ev_load_short), .ev_open_load(ev_open_load),
    .diag_byte(diag_byte), .fault_stored(fault_stored)
  );

  task automatic step(input logic en, input logic dis, input logic uv,
                      input logic [10:0] ev, input string tag);
    exp_t it;
    logic clr_m;
    logic [1:0] f [2];
    @(negedge clk);
    en_in = en; dis_in = dis; uv_in = uv;
    ev_cur_lim = ev[B_LIM]; ev_cur_red = ev[B_RED]; ev_over_temp = ev[B_OT];
    ev_short_gnd = {ev[B_G1], ev[B_G0]}; ev_short_sup = {ev[B_S1], ev[B_S0]};
    ev_load_short = ev[B_LS]; ev_open_load = ev[B_OL];
    clr_req = ev[B_CLR]; mode_enter = ev[B_MODE];
    // R8 clear sources, then R9 events are applied after the clear
    clr_m = ev[B_CLR] | ev[B_MODE] | (en & !m_en_p & !dis) | (!dis & m_dis_p & en);
    if (clr_m) begin
      m_lim = 0; m_red = 0; m_ot = 0; m_ls = 0; m_ol = 0; m_gnd = 0; m_sup = 0;
    end
    m_lim |= ev[B_LIM]; m_red |= ev[B_RED]; m_ot |= ev[B_OT];
    m_ls |= ev[B_LS]; m_ol |= ev[B_OL];
    m_gnd |= {ev[B_G1], ev[B_G0]}; m_sup |= {ev[B_S1], ev[B_S0]};
    for (int i = 0; i < 2; i++) begin
      if (uv) f[i] = 2'b00;
      else if (m_ls) f[i] = (i == 0) ? 2'b01 : 2'b10;
      else if (m_gnd[i]) f[i] = 2'b01;
      else if (m_sup[i]) f[i] = 2'b10;
      else if (m_ol) f[i] = 2'b00;
      else f[i] = 2'b11;
    end
    it.b = {en & !dis, !m_ot, !m_red, !m_lim, f[1], f[0]};
    it.sf = m_lim | m_red | m_ot | m_ls | m_ol | (|m_gnd) | (|m_sup);
    it.tag = tag;
    sb_q.push_back(it);
    m_en_p = en; m_dis_p = dis;
  endtask

  // monitor: compares one expected item per clock, after the edge settles
  always @(posedge clk) begin
    #2;
    if (sb_q.size() != 0) begin
      mon_it = sb_q.pop_front();
      checks++;
      if (diag_byte !== mon_it.b || fault_stored !== mon_it.sf) begin
        errors++;
        $display("FAIL %s: byte %02h flag %0b, expected byte %02h flag %0b",
                 mon_it.tag, diag_byte, fault_stored, mon_it.b, mon_it.sf);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en_in = 0; dis_in = 1; uv_in = 0; mode_enter = 0; clr_req = 0;
    ev_cur_lim = 0; ev_cur_red = 0; ev_over_temp = 0; ev_load_short = 0;
    ev_open_load = 0; ev_short_gnd = 0; ev_short_sup = 0;
    m_lim = 0; m_red = 0; m_ot = 0; m_ls = 0; m_ol = 0; m_gnd = 0; m_sup = 0;
    m_en_p = 0; m_dis_p = 1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (diag_byte !== 8'hFF || fault_stored !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: byte %02h flag %0b, expected byte ff flag 0",
               diag_byte, fault_stored);
    end
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    step(0, 1, 0, 11'h0, "R2 disabled");
    step(1, 0, 0, 11'h0, "R2 enabled");
    step(1, 0, 0, 11'(1 << B_LIM), "R3 current limit");
    step(1, 0, 0, 11'h0, "R3 hold");
    step(1, 0, 0, 11'(1 << B_RED), "R3 current reduction");
    step(1, 0, 0, 11'(1 << B_OT), "R3 over-temperature");
    step(1, 0, 0, 11'(1 << B_CLR), "R8 clear request");
    step(1, 0, 0, 11'(1 << B_G0), "R4 ground short out1");
    step(1, 0, 0, 11'(1 << B_S1), "R4 supply short out2");
    step(1, 0, 0, 11'(1 << B_OL), "R6 short over open");
    step(1, 0, 0, 11'(1 << B_CLR), "R8 clear");
    step(1, 0, 0, 11'(1 << B_OL), "R4 open load");
    step(1, 0, 0, 11'(1 << B_S0), "R6 supply over open");
    step(1, 0, 0, 11'(1 << B_G0), "R6 ground over supply");
    step(1, 0, 0, 11'(1 << B_LS), "R5 load short");
    step(1, 0, 1, 11'h0, "R7 under-voltage blank");
    step(1, 0, 1, 11'(1 << B_G1), "R7 blank with event");
    step(1, 0, 0, 11'h0, "R7 restore");
    step(1, 0, 0, 11'((1 << B_CLR) | (1 << B_OT)), "R9 event with clear");
    step(1, 0, 0, 11'h0, "R10 summary");
    step(1, 0, 0, 11'(1 << B_MODE), "R8 mode entry");
    step(1, 0, 0, 11'(1 << B_LIM), "R3 limit again");
    step(0, 0, 0, 11'h0, "R2 enable low");
    step(1, 0, 0, 11'h0, "R8 enable rise");
    step(1, 0, 0, 11'(1 << B_OT), "R3 over-temp again");
    step(1, 1, 0, 11'h0, "R2 disable high");
    step(1, 0, 0, 11'h0, "R8 disable fall");
    step(1, 0, 0, 11'(1 << B_OT), "R10 stored again");
    step(0, 1, 0, 11'h0, "R2 both off");
    step(1, 1, 0, 11'h0, "R8 rise under disable keeps");
    step(1, 0, 0, 11'h0, "R8 disable fall clears");
    step(1, 0, 0, 11'h0, "R10 empty");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule